// File: doc/BRIEF.md
# Grouped Exception Priority Arbiter

This block collects exception requests raised by a processor core and picks the single one that gets serviced next. Sources fall into three priority groups. The first group holds the fatal sources: reset, bus fault and misaligned access. The second group holds trace, external interrupt, undefined opcode and privilege fault. The third group holds the faults raised by the current instruction: software trap, overflow trap, bounds fault and divide-by-zero. An external interrupt only competes when its level is strictly above the current mask. Otherwise it stays pending, unseen by the arbitration.

Each request pulse is stored in a pending register until its source wins. A win is latched into registered outputs: a grant flag, the one-hot winning source and an 8-bit vector number. These hold until the consumer pulses acknowledge. Sources that lost stay pending and compete again in the cycle after the grant drops. Building the stack frame and fetching the vector are left to the consumer.

Top module: `exc_grp_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, all pending requests clear, and after that edge `grant` is 0, `win_src` is 0 and `vec_num` is 0.
- R2: Request bit positions are: 0 reset, 1 bus fault, 2 misaligned access, 3 trace, 4 interrupt, 5 undefined opcode, 6 privilege fault, 7 software trap, 8 overflow trap, 9 bounds fault, 10 divide-by-zero. Among eligible pending requests, the lowest bit wins, so bit 0 beats bit 1 and bit 1 beats bit 2. Every first-group source beats every other source.
- R3: Within the second group the order is trace, then interrupt, then undefined opcode, then privilege fault. All four beat the third group.
- R4: Third-group sources lose to every other source. Among themselves they resolve in bit order 7, 8, 9, 10, and exactly one source is picked.
- R5: A pending interrupt is eligible only when `irq_level` is greater than `irq_mask`. Otherwise it stays pending, with no grant for it, until the comparison becomes true.
- R6: Fixed vector numbers are: reset 0, bus fault 2, misaligned access 3, undefined opcode 4, divide-by-zero 5, bounds fault 6, overflow trap 7, privilege fault 8, trace 9.
- R7: An interrupt's vector is 24 plus `irq_level` as sampled at the latching edge. When `irq_spurious` is high at that edge, the vector is 24.
- R8: A software trap's vector is 32 plus `trap_num` as sampled at the latching edge, which covers 32 to 47.
- R9: While `grant` is high, `win_src` and `vec_num` stay constant and no new winner is latched. If `ack` is high at an edge while `grant` is high, then after that edge `grant`, `win_src` and `vec_num` are 0.
- R10: Losing requests stay pending and are granted later in priority order. The winning source's pending bit clears at the latching edge, and a new request from that same source arriving at that edge is absorbed.
- R11: A request sampled at edge k becomes pending at edge k. If it wins, `grant` rises at edge k+1.
- R12: While `grant` is high, `win_src` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 11 | Request pulses, bit positions as in R2 |
| irq_level | input | 3 | Level of the requesting interrupt |
| irq_mask | input | 3 | Current interrupt mask |
| irq_spurious | input | 1 | Forces the interrupt vector to 24 |
| trap_num | input | 4 | Software trap number |
| ack | input | 1 | Releases the current grant |
| grant | output | 1 | A latched winner is presented |
| win_src | output | 11 | One-hot winning source |
| vec_num | output | 8 | Vector number of the winner |

## Verification
The checks assume that `irq_level`, `irq_mask`, `irq_spurious` and `trap_num` as sampled at the latching edge define the winner's eligibility and vector. They also assume that `ack` raised while no grant is shown has no effect. The stimulus changes all inputs only on the falling clock edge, so each rising edge sees settled values. It also raises `ack` freely, including with no grant outstanding. In real use the third-group sources are mutually exclusive. The stimulus deliberately breaks that assumption, both in the directed all-sources burst and in the random phase, so that the safeguard ordering is exercised.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    localparam int unsigned NSRC    = 11;
    localparam int unsigned LVL_W   = 3;
    localparam int unsigned TRAPN_W = 4;
    localparam int unsigned VEC_W   = 8;

    localparam logic [VEC_W-1:0] IRQ_VEC_BASE  = 8'd24;
    localparam logic [VEC_W-1:0] TRAP_VEC_BASE = 8'd32;

    typedef enum logic [3:0] {
        SRC_RST     = 4'd0,
        SRC_BUSERR  = 4'd1,
        SRC_ALIGN   = 4'd2,
        SRC_TRACE   = 4'd3,
        SRC_IRQ     = 4'd4,
        SRC_UNDEF   = 4'd5,
        SRC_PRIV    = 4'd6,
        SRC_TRAP    = 4'd7,
        SRC_OVF     = 4'd8,
        SRC_BOUNDS  = 4'd9,
        SRC_ZDIV    = 4'd10
    } exc_src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic              busy;
        src_vec_t          win;
        logic [VEC_W-1:0]  vnum;
    } grant_state_t;

    function automatic logic [VEC_W-1:0] src_vector(
        input exc_src_e           s,
        input logic [LVL_W-1:0]   lvl,
        input logic               spur,
        input logic [TRAPN_W-1:0] tnum
    );
        logic [VEC_W-1:0] v;
        case (s)
            SRC_RST:    v = 8'd0;
            SRC_BUSERR: v = 8'd2;
            SRC_ALIGN:  v = 8'd3;
            SRC_TRACE:  v = 8'd9;
            SRC_IRQ:    v = spur ? IRQ_VEC_BASE : IRQ_VEC_BASE + VEC_W'(lvl);
            SRC_UNDEF:  v = 8'd4;
            SRC_PRIV:   v = 8'd8;
            SRC_TRAP:   v = TRAP_VEC_BASE + VEC_W'(tnum);
            SRC_OVF:    v = 8'd7;
            SRC_BOUNDS: v = 8'd6;
            SRC_ZDIV:   v = 8'd5;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/exc_pend_reg.sv
module exc_pend_reg
    import exc_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t pend_o
);

    // Pending store: new pulses OR in, the latched winner drops out.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o | set_i) & ~clr_i;
        end
    end

endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_arb_pkg::*;
(
    input  src_vec_t         pend_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] irq_mask_i,
    output src_vec_t         sel_o,
    output logic             any_o
);

    src_vec_t elig;

    // Interrupt is gated by the level/mask comparison; all others pass.
    always_comb begin
        elig = pend_i;
        elig[int'(SRC_IRQ)] = pend_i[int'(SRC_IRQ)] & (irq_level_i > irq_mask_i);
    end

    // Bit order is priority order: lowest eligible index wins.
    for (genvar i = 0; i < NSRC; i++) begin : g_pick
        if (i == 0) begin : g_head
            assign sel_o[i] = elig[i];
        end else begin : g_tail
            assign sel_o[i] = elig[i] & ~(|elig[i-1:0]);
        end
    end

    assign any_o = |elig;

    // R4: the chain never picks more than one source, and picks one when any is eligible
    always_comb begin
        a_r4_single_pick: assert (any_o ? $onehot(sel_o) : (sel_o == '0));
    end

endmodule

// File: rtl/exc_vec_enc.sv
module exc_vec_enc
    import exc_arb_pkg::*;
(
    input  src_vec_t           sel_i,
    input  logic [LVL_W-1:0]   irq_level_i,
    input  logic               irq_spurious_i,
    input  logic [TRAPN_W-1:0] trap_num_i,
    output logic [VEC_W-1:0]   vnum_o
);

    always_comb begin
        vnum_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_i[i]) begin
                vnum_o |= src_vector(exc_src_e'(4'(i)), irq_level_i,
                                     irq_spurious_i, trap_num_i);
            end
        end
    end

endmodule

// File: rtl/exc_grp_arbiter.sv
module exc_grp_arbiter
    import exc_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    exc_req,
    input  logic [LVL_W-1:0]   irq_level,
    input  logic [LVL_W-1:0]   irq_mask,
    input  logic               irq_spurious,
    input  logic [TRAPN_W-1:0] trap_num,
    input  logic               ack,
    output logic               grant,
    output logic [NSRC-1:0]    win_src,
    output logic [VEC_W-1:0]   vec_num
);

    src_vec_t         pend;
    src_vec_t         sel;
    src_vec_t         clr;
    logic             any;
    logic             take;
    logic [VEC_W-1:0] vnum;
    grant_state_t     st;

    exc_pend_reg u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (exc_req),
        .clr_i  (clr),
        .pend_o (pend)
    );

    exc_prio_sel u_sel (
        .pend_i      (pend),
        .irq_level_i (irq_level),
        .irq_mask_i  (irq_mask),
        .sel_o       (sel),
        .any_o       (any)
    );

    exc_vec_enc u_vec (
        .sel_i          (sel),
        .irq_level_i    (irq_level),
        .irq_spurious_i (irq_spurious),
        .trap_num_i     (trap_num),
        .vnum_o         (vnum)
    );

    assign take = !st.busy && any;
    assign clr  = take ? sel : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (take) begin
            st.busy <= 1'b1;
            st.win  <= sel;
            st.vnum <= vnum;
        end else if (st.busy && ack) begin
            st <= '0;
        end
    end

    assign grant   = st.busy;
    assign win_src = st.win;
    assign vec_num = st.vnum;

    // R12: exactly one winner bit while granted, none otherwise
    a_r12_onehot_win: assert property (@(posedge clk) disable iff (rst)
        grant ? $onehot(win_src) : (win_src == '0));

    // R9: the latched winner is frozen until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (grant && !ack) |=> (grant && $stable(win_src) && $stable(vec_num)));

    // R9: acknowledge releases the grant on the next edge
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (grant && ack) |=> !grant);

    // R2: a pending first-group reset request always takes the next grant
    a_r2_reset_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant) && $past(pend[int'(SRC_RST)])) |-> win_src[int'(SRC_RST)]);

    // R5: an interrupt is only granted when its level exceeded the mask
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant) && win_src[int'(SRC_IRQ)]) |-> ($past(irq_level) > $past(irq_mask)));

endmodule

// File: tb/exc_grp_arbiter_tb_top.sv
`timescale 1ns/1ps
module exc_grp_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] exc_req;
    logic [2:0]  irq_level;
    logic [2:0]  irq_mask;
    logic        irq_spurious;
    logic [3:0]  trap_num;
    logic        ack;
    logic        grant;
    logic [10:0] win_src;
    logic [7:0]  vec_num;

    always #2 clk = ~clk;

    exc_grp_arbiter dut_i (
        .clk          (clk),
        .rst          (rst),
        .exc_req      (exc_req),
        .irq_level    (irq_level),
        .irq_mask     (irq_mask),
        .irq_spurious (irq_spurious),
        .trap_num     (trap_num),
        .ack          (ack),
        .grant        (grant),
        .win_src      (win_src),
        .vec_num      (vec_num)
    );

    int    n_vec  = 0;
    int    n_bad  = 0;
    string tag    = "R1";
    bit    done   = 0;

    // Behavioural reference state
    bit [10:0] m_pend;
    bit        m_busy;
    int        m_win;
    int        m_vec;

    function automatic int exp_vector(int s, int lvl, bit spur, int tn);
        case (s)
            0: return 0;
            1: return 2;
            2: return 3;
            3: return 9;
            4: return spur ? 24 : 24 + lvl;
            5: return 4;
            6: return 8;
            7: return 32 + tn;
            8: return 7;
            9: return 6;
            default: return 5;
        endcase
    endfunction

    always @(posedge clk) begin
        int pick;
        bit [10:0] nxt;
        if (rst) begin
            m_pend = '0; m_busy = 0; m_win = -1; m_vec = 0;
        end else begin
            pick = -1;
            if (!m_busy) begin
                for (int i = 0; i < 11; i++) begin
                    if (pick < 0 && m_pend[i] && (i != 4 || irq_level > irq_mask)) pick = i;
                end
            end
            nxt = m_pend | exc_req;
            if (pick >= 0) begin
                m_busy = 1; m_win = pick;
                m_vec = exp_vector(pick, int'(irq_level), irq_spurious, int'(trap_num));
                nxt[pick] = 1'b0;
            end else if (m_busy && ack) begin
                m_busy = 0; m_win = -1; m_vec = 0;
            end
            m_pend = nxt;
        end
    end

    task automatic tick();
        logic [10:0] ew;
        @(negedge clk);
        ew = m_busy ? (11'd1 << m_win) : 11'd0;
        n_vec++;
        if (grant !== m_busy || win_src !== ew || vec_num !== 8'(m_vec)) begin
            n_bad++;
            $display("FAIL %s: grant=%0d win=%b vec=%0d expected grant=%0d win=%b vec=%0d",
                     tag, grant, win_src, vec_num, m_busy, ew, m_vec);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            exc_req = '0;
            ack = 1'b0;
        end
    endtask

    // Acknowledge whatever the reference shows as granted
    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            exc_req = '0;
            ack = m_busy;
        end
        ack = 1'b0;
    endtask

    task automatic pulse(logic [10:0] r);
        tick();
        exc_req = r;
        ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; exc_req = '0; irq_level = 3'd0; irq_mask = 3'd0;
        irq_spurious = 1'b0; trap_num = 4'd0; ack = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        idle(2);

        // R2 R3 R4 R10 R11 R6: all sources at once, drained in priority order
        tag = "R2 R3 R4 R10 R11 R6";
        irq_level = 3'd7; irq_mask = 3'd0; trap_num = 4'd3;
        pulse(11'h7FF);
        drain(30);

        // R5 R7: interrupt held under mask, then released
        tag = "R5 R7";
        irq_level = 3'd3; irq_mask = 3'd5;
        pulse(11'h010);
        idle(6);
        irq_level = 3'd6;
        drain(6);
        irq_level = 3'd5; irq_mask = 3'd5;
        pulse(11'h010);
        idle(4);
        irq_mask = 3'd2;
        drain(5);
        irq_level = 3'd2; irq_mask = 3'd0; irq_spurious = 1'b1;
        pulse(11'h010);
        drain(5);
        irq_spurious = 1'b0;

        // R8: trap vector range ends and middle
        tag = "R8";
        trap_num = 4'd0;  pulse(11'h080); drain(5);
        trap_num = 4'd15; pulse(11'h080); drain(5);
        trap_num = 4'd9;  pulse(11'h080); drain(5);

        // R9 R10: grant held without ack while another request arrives
        tag = "R9 R10";
        pulse(11'h008);
        idle(2);
        pulse(11'h400);
        idle(5);
        drain(6);

        // R1: reset clears a pending and a granted request
        tag = "R1";
        irq_mask = 3'd7;
        pulse(11'h012);
        idle(3);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        irq_mask = 3'd0;
        idle(3);

        // R2..R12 under random traffic
        tag = "R12 R4 R9";
        for (int k = 0; k < 4000; k++) begin
            tick();
            exc_req      = ($urandom % 4 == 0) ? 11'($urandom) & 11'($urandom) : '0;
            ack          = ($urandom % 3 == 0);
            irq_level    = 3'($urandom);
            irq_mask     = 3'($urandom);
            irq_spurious = ($urandom % 8 == 0);
            trap_num     = 4'($urandom);
            rst          = ($urandom % 500 == 0);
        end
        rst = 1'b0;
        exc_req = '0;
        drain(40);
        finish_run();
    end

endmodule